// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Port

This block is a parameterised register (eight bits by default) that on each rising clock edge either keeps its contents, moves them one place toward the high end, moves them one place toward the low end, or takes a new word from the parallel port. A 2-bit select picks the operation. An active-low synchronous clear takes priority over the select. The parallel port is shared: the same lines carry load data in and register contents out. Inside the chip this is modelled as a separate input vector, output vector and output-enable. The enable drops on its own while a load is selected, so the lines are free to act as inputs.

Each end of the register has its own serial input. Both end bits are also driven on dedicated serial outputs that ignore the output enables. Several instances can therefore be chained into a wider shifter, with the parallel port still tri-stated. The operation decoded each cycle is one of five named states: OP_CLEAR (clear low), OP_HOLD (select 00), OP_SHR (select 01, toward the high end), OP_SHL (select 10, toward the low end) and OP_LOAD (select 11). Every state can follow any other on the next edge, as the reset and select inputs decide.

Top module: `usr_shreg_top`

## Requirements
- R1: When srst_n is 0 at a rising edge, every register bit becomes 0 whatever sel, par_in or the serial inputs hold. A clear requested together with sel=11 still clears.
- R2: With srst_n=1 and sel=00 the register keeps its value, and par_in and the serial inputs have no effect.
- R3: With srst_n=1 and sel=01 (sel[0]=1), the register becomes {q[W-2:0], ser_in_lo}. ser_in_lo enters bit 0 and the old bit W-1 is dropped.
- R4: With srst_n=1 and sel=10 (sel[1]=1), the register becomes {ser_in_hi, q[W-1:1]}. ser_in_hi enters bit W-1 and the old bit 0 is dropped.
- R5: With srst_n=1 and sel=11 the register takes par_in, each bit into the same position.
- R6: par_out always equals the register contents, whatever the state of the enables.
- R7: par_oe is 1 exactly when oe_a_n=0, oe_b_n=0 and sel is not 11. It is 0 whenever a load is selected, even with both enables low.
- R8: ser_out_lo always equals register bit 0 and ser_out_hi always equals bit W-1, independent of oe_a_n and oe_b_n.
- R9: Clear, hold, shift and load update the register in the same way while par_oe is 0 as while it is 1.
- R10: Two instances chained form one 2W-bit shifter in both directions. In the chain, the low instance's ser_out_hi feeds the high instance's ser_in_lo, and the high instance's ser_out_lo feeds the low instance's ser_in_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| srst_n | input | 1 | Synchronous clear, active low, top priority |
| sel | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_lo | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_in_hi | input | 1 | Serial bit entering bit W-1 on a downward shift |
| oe_a_n | input | 1 | Parallel output enable, active low |
| oe_b_n | input | 1 | Second parallel output enable, active low |
| par_in | input | W | Parallel load data (input side of the shared port) |
| par_out | output | W | Register contents (output side of the shared port) |
| par_oe | output | 1 | Drive enable for the shared port |
| ser_out_lo | output | 1 | Register bit 0, always driven |
| ser_out_hi | output | 1 | Register bit W-1, always driven |

## Verification
The embedded properties assume that srst_n is low at the first rising edge. They also assume that the select, serial inputs and enables carry known values at every edge after that, since the next-value checks compare against the previous cycle's inputs. The stimulus meets both conditions. It starts inside a clear cycle, drives every input from the falling edge only, and never leaves an input undriven. That keeps each value stable around the rising edge at which the register samples it.

// File: rtl/usr_pkg.sv
package usr_pkg;
    typedef enum logic [2:0] {
        OP_CLEAR,
        OP_HOLD,
        OP_SHR,
        OP_SHL,
        OP_LOAD
    } op_e;

    localparam logic [1:0] SEL_HOLD = 2'b00;
    localparam logic [1:0] SEL_SHR  = 2'b01;
    localparam logic [1:0] SEL_SHL  = 2'b10;
    localparam logic [1:0] SEL_LOAD = 2'b11;
endpackage

// File: rtl/usr_op_decode.sv
module usr_op_decode
    import usr_pkg::*;
(
    input  logic       srst_n,
    input  logic [1:0] sel,
    output op_e        op
);
    always_comb begin
        if (!srst_n) begin
            op = OP_CLEAR;
        end else begin
            unique case (sel)
                SEL_HOLD: op = OP_HOLD;
                SEL_SHR:  op = OP_SHR;
                SEL_SHL:  op = OP_SHL;
                default:  op = OP_LOAD;
            endcase
        end
    end
endmodule

// File: rtl/usr_next_value.sv
module usr_next_value
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] cur,
    input  logic         ser_lo,
    input  logic         ser_hi,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] nxt
);
    localparam int MSB = W - 1;

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_HOLD:  nxt = cur;
            OP_SHR:   nxt = {cur[MSB-1:0], ser_lo};
            OP_SHL:   nxt = {ser_hi, cur[MSB:1]};
            OP_LOAD:  nxt = load_val;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/usr_oe_ctrl.sv
module usr_oe_ctrl
    import usr_pkg::*;
(
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    input  logic [1:0] sel,
    output logic       drive_en
);
    logic load_sel;

    always_comb begin
        load_sel = (sel == SEL_LOAD);
        drive_en = !oe_a_n && !oe_b_n && !load_sel;
    end
endmodule

// File: rtl/usr_shreg_top.sv
module usr_shreg_top
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         srst_n,
    input  logic [1:0]   sel,
    input  logic         ser_in_lo,
    input  logic         ser_in_hi,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] par_out,
    output logic         par_oe,
    output logic         ser_out_lo,
    output logic         ser_out_hi
);
    localparam int MSB = W - 1;

    op_e          op;
    logic [W-1:0] q_r;
    logic [W-1:0] q_nxt;
    logic         drive_en;

    usr_op_decode u_dec (
        .srst_n (srst_n),
        .sel    (sel),
        .op     (op)
    );

    usr_next_value #(.W(W)) u_nxt (
        .op       (op),
        .cur      (q_r),
        .ser_lo   (ser_in_lo),
        .ser_hi   (ser_in_hi),
        .load_val (par_in),
        .nxt      (q_nxt)
    );

    usr_oe_ctrl u_oe (
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .sel      (sel),
        .drive_en (drive_en)
    );

    always_ff @(posedge clk) begin
        q_r <= q_nxt;
    end

    always_comb begin
        par_out    = q_r;
        par_oe     = drive_en;
        ser_out_lo = q_r[0];
        ser_out_hi = q_r[MSB];
    end

    // R1: clear wins over any select
    a_r1_clear: assert property (@(posedge clk)
        !srst_n |=> (q_r == '0));

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (!srst_n)
        (sel == SEL_HOLD) |=> $stable(q_r));

    // R3
    a_r3_shift_up: assert property (@(posedge clk) disable iff (!srst_n)
        (sel == SEL_SHR) |=> (q_r == {$past(q_r[MSB-1:0]), $past(ser_in_lo)}));

    // R4
    a_r4_shift_down: assert property (@(posedge clk) disable iff (!srst_n)
        (sel == SEL_SHL) |=> (q_r == {$past(ser_in_hi), $past(q_r[MSB:1])}));

    // R5
    a_r5_load: assert property (@(posedge clk) disable iff (!srst_n)
        (sel == SEL_LOAD) |=> (q_r == $past(par_in)));

    // R7
    a_r7_off_in_load: assert property (@(posedge clk) disable iff (!srst_n)
        (sel == SEL_LOAD) |-> !par_oe);

    a_r7_off_by_enable: assert property (@(posedge clk) disable iff (!srst_n)
        (oe_a_n || oe_b_n) |-> !par_oe);

    // R8
    a_r8_serial_ends: assert property (@(posedge clk) disable iff (!srst_n)
        (ser_out_lo == par_out[0]) && (ser_out_hi == par_out[MSB]));
endmodule

// File: tb/usr_shreg_top_tb_top.sv
module usr_shreg_top_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         srst_n = 1'b0;
    logic [1:0]   sel = 2'b11;
    logic         ser_in_lo = 1'b0;
    logic         ser_in_hi = 1'b0;
    logic         oe_a_n = 1'b0;
    logic         oe_b_n = 1'b0;
    logic [W-1:0] par_in = 8'h5A;
    logic [W-1:0] par_in2 = 8'hC3;
    logic [W-1:0] par_out;
    logic         par_oe;
    logic         ser_out_lo;
    logic         ser_out_hi;

    logic [W-1:0] c_lo_out, c_hi_out;
    logic         c_lo_oe, c_hi_oe;
    logic         c_lo_slo, c_lo_shi, c_hi_slo, c_hi_shi;

    always #10 clk = ~clk;

    usr_shreg_top #(.W(W)) dut_i (
        .clk(clk), .srst_n(srst_n), .sel(sel),
        .ser_in_lo(ser_in_lo), .ser_in_hi(ser_in_hi),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .par_in(par_in),
        .par_out(par_out), .par_oe(par_oe),
        .ser_out_lo(ser_out_lo), .ser_out_hi(ser_out_hi)
    );

    // R10: chained pair
    usr_shreg_top #(.W(W)) chain_lo_i (
        .clk(clk), .srst_n(srst_n), .sel(sel),
        .ser_in_lo(ser_in_lo), .ser_in_hi(c_hi_slo),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .par_in(par_in),
        .par_out(c_lo_out), .par_oe(c_lo_oe),
        .ser_out_lo(c_lo_slo), .ser_out_hi(c_lo_shi)
    );

    usr_shreg_top #(.W(W)) chain_hi_i (
        .clk(clk), .srst_n(srst_n), .sel(sel),
        .ser_in_lo(c_lo_shi), .ser_in_hi(ser_in_hi),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .par_in(par_in2),
        .par_out(c_hi_out), .par_oe(c_hi_oe),
        .ser_out_lo(c_hi_slo), .ser_out_hi(c_hi_shi)
    );

    typedef struct {
        logic [W-1:0]   q;
        logic           oe;
        logic [2*W-1:0] cq;
        string          tag;
    } item_t;

    item_t          sb_q[$];
    logic [W-1:0]   m_q;
    logic [2*W-1:0] m_cq;
    int             n_vec  = 0;
    int             n_fail = 0;
    bit             done   = 1'b0;

    task automatic step(input string tag, input logic rn, input logic [1:0] s,
                        input logic slo, input logic shi, input logic oa, input logic ob,
                        input logic [W-1:0] p, input logic [W-1:0] p2);
        item_t it;
        @(negedge clk);
        srst_n = rn; sel = s; ser_in_lo = slo; ser_in_hi = shi;
        oe_a_n = oa; oe_b_n = ob; par_in = p; par_in2 = p2;
        if (!rn) begin
            m_q = '0; m_cq = '0;
        end else begin
            case (s)
                2'b01: begin m_q = {m_q[W-2:0], slo}; m_cq = {m_cq[2*W-2:0], slo}; end
                2'b10: begin m_q = {shi, m_q[W-1:1]}; m_cq = {shi, m_cq[2*W-1:1]}; end
                2'b11: begin m_q = p; m_cq = {p2, p}; end
                default: ;
            endcase
        end
        it.q   = m_q;
        it.oe  = !oa && !ob && (s != 2'b11);
        it.cq  = m_cq;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: mid-high phase after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                item_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (par_out !== e.q) begin
                    n_fail++;
                    $display("FAIL %s R6 par_out act=%h exp=%h", e.tag, par_out, e.q);
                end
                if (par_oe !== e.oe) begin
                    n_fail++;
                    $display("FAIL %s R7 par_oe act=%b exp=%b", e.tag, par_oe, e.oe);
                end
                if (ser_out_lo !== e.q[0] || ser_out_hi !== e.q[W-1]) begin
                    n_fail++;
                    $display("FAIL %s R8 serial act=%b%b exp=%b%b", e.tag,
                             ser_out_hi, ser_out_lo, e.q[W-1], e.q[0]);
                end
                if ({c_hi_out, c_lo_out} !== e.cq) begin
                    n_fail++;
                    $display("FAIL %s R10 chain act=%h exp=%h", e.tag,
                             {c_hi_out, c_lo_out}, e.cq);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: clear beats a load request
        step("R1", 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);
        step("R1", 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h0F);
        // R5 load
        step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C);
        // R2 hold, par_in and serial inputs ignored
        step("R2", 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF);
        step("R2", 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00);
        // R3 shift up with varied serial bits
        step("R3", 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R3", 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'h00);
        step("R3", 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF);
        // R4 shift down
        step("R4", 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R4", 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h00);
        step("R4", 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF);
        // R9 operations with port disabled
        step("R9", 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        step("R9", 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        step("R9", 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 8'h81, 8'h7E);
        step("R9", 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
        step("R9", 1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF);
        // R5 boundary words, R8 end bits shifted out
        step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'h01);
        step("R8", 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 8'h80);
        step("R8", 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        step("R5", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
        step("R1", 1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);
        // R10 chained shifting both directions
        step("R10", 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81, 8'h3C);
        for (int i = 0; i < 12; i++)
            step("R10", 1'b1, 2'b01, 1'(i % 3 == 0), 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        for (int i = 0; i < 12; i++)
            step("R10", 1'b1, 2'b10, 1'b0, 1'(i % 2), 1'b0, 1'b0, 8'h00, 8'h00);
        step("R2", 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule